// File: doc/BRIEF.md
# Interrupt-Entry Stack Push Sequencer

This block drives the external bus of an 8-bit processor while it enters a software break or a hardware interrupt. Both kinds of entry use the same sequence. The control logic asserts `start` for one cycle, during the cycle in which the break is decoded. From then on the sequencer owns the bus. It pushes the program counter high byte, then the low byte, then the status byte onto the stack in page one. It reads the two-byte vector at the top of memory and then fetches the first opcode at the vector address. The last cycle raises `done` for one cycle. During that cycle the new program counter appears on `pc_out` and the decremented stack pointer on `sp_out`.

The memory is asynchronous SRAM, which needs its write-enable strobe to drop between two separate writes. The default mode therefore interleaves the bus cycles: write, read, write, read, write, fetch. This keeps the whole entry at seven cycles, counting the decode cycle. Setting `slow_mode` at start keeps the conventional order of three writes followed by two vector reads. In that mode one idle cycle is placed after each of the first two writes, which gives nine cycles in total.

None of the pins carry a data stream, so there is no valid/ready handshake and no back-pressure. `start` is a plain command that is taken only while the block is idle. The bus has no wait states: each read-data byte is sampled at the clock edge that ends its read cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `we`=0, `rw`=1 (read), `done`=0 and `busy`=0.
- R2: With `slow_mode`=0 at start, the six cycles after the start cycle are, in order:
  - write of PC[15:8] to 0x0100+SP;
  - read of 0xFFFE;
  - write of PC[7:0] to 0x0100+SP-1;
  - read of 0xFFFF;
  - write of the status byte to 0x0100+SP-2;
  - read of the new PC.
- R3: `done` is high for exactly one cycle, the opcode-fetch cycle. That is 6 cycles after the start cycle in interleaved mode and 8 cycles after it in slow mode. It is low in every other cycle.
- R4: `we` is never high on two consecutive cycles. While `we`=1, `rw`=0 and `wdata` carries the pushed byte.
- R5: The new PC is {byte read at 0xFFFF, byte read at 0xFFFE}. It is the fetch address and is shown on `pc_out` from the `done` cycle until the next start.
- R6: Stack addresses stay within page one. The low byte wraps modulo 256, so SP=0x01 pushes to 0x0101, 0x0100 and 0x01FF. `sp_out` = (SP-3) mod 256.
- R7: With `slow_mode`=1 at start, the eight cycles after the start cycle are, in order:
  - write of PC[15:8];
  - idle;
  - write of PC[7:0];
  - idle;
  - write of the status byte;
  - read of 0xFFFE;
  - read of 0xFFFF;
  - fetch at the new PC.

  The stack addresses are the same as in R2.
- R8: Every cycle that is not a write, whether idle or a sequence read, has `we`=0 and `rw`=1.
- R9: `start` is ignored while `busy`=1. PC, status, SP and mode are captured at start, so later changes on those inputs do not alter the bytes pushed or their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle entry request in the decode cycle |
| slow_mode | input | 1 | 1 selects the padded conventional order |
| pc_in | input | 16 | Program counter to push |
| psr_in | input | 8 | Status byte to push |
| sp_in | input | 8 | Stack pointer before the pushes |
| rdata | input | 8 | Read data, sampled at the end of each read cycle |
| addr | output | 16 | Registered bus address |
| wdata | output | 8 | Registered write data |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| we | output | 1 | Registered write-enable, high in write cycles only |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse during the opcode fetch |
| pc_out | output | 16 | New program counter (vector) |
| sp_out | output | 8 | Stack pointer after three pushes |

## Verification
A wrong state transition shows on the bus within one cycle. It appears as a write where a read is expected, as a `we` that stays high across two cycles, or as a misplaced `done`. A wrong captured context or a wrong stack offset shows as a wrong `addr` or `wdata` in the very push cycle that uses it. A bad vector latch shows only at the fetch cycle, as a wrong fetch address and a wrong `pc_out`. For that reason every cycle of each run is compared against the expected trace, over both modes, stack pointers at the page edges, and inputs that change in the middle of a sequence.

// File: rtl/ies_pkg.sv
package ies_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_PSR,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_GAP_A,
    ST_GAP_B,
    ST_FETCH
  } ies_state_e;
endpackage

// File: rtl/ies_fsm.sv
module ies_fsm
  import ies_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       slow_mode,
  output ies_state_e state_q,
  output ies_state_e state_d,
  output logic       load,
  output logic       busy
);
  logic mode_q;

  assign busy = (state_q != ST_IDLE);
  assign load = start && !busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = ST_PUSH_HI;
      ST_PUSH_HI:  state_d = mode_q ? ST_GAP_A    : ST_VEC_LO;
      ST_VEC_LO:   state_d = mode_q ? ST_VEC_HI   : ST_PUSH_LO;
      ST_PUSH_LO:  state_d = mode_q ? ST_GAP_B    : ST_VEC_HI;
      ST_VEC_HI:   state_d = mode_q ? ST_FETCH    : ST_PUSH_PSR;
      ST_PUSH_PSR: state_d = mode_q ? ST_VEC_LO   : ST_FETCH;
      ST_GAP_A:    state_d = ST_PUSH_LO;
      ST_GAP_B:    state_d = ST_PUSH_PSR;
      ST_FETCH:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) mode_q <= slow_mode;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state_q != ST_PUSH_HI)); // R9
endmodule

// File: rtl/ies_ctx.sv
module ies_ctx
  import ies_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ies_state_e        state_q,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] sp_in,
  output logic [ADDR_W-1:0] cur_pc,
  output logic [DATA_W-1:0] cur_psr,
  output logic [DATA_W-1:0] cur_sp,
  output logic [ADDR_W-1:0] vec_next,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] PUSH_CNT = DATA_W'(3);

  logic [ADDR_W-1:0] pc_q, vec_q;
  logic [DATA_W-1:0] psr_q, sp_q, lo_q;

  // Bypass so the first push, registered at the start edge, sees fresh inputs.
  assign cur_pc  = load ? pc_in  : pc_q;
  assign cur_psr = load ? psr_in : psr_q;
  assign cur_sp  = load ? sp_in  : sp_q;

  assign vec_next = (state_q == ST_VEC_HI) ? {rdata[HI_W-1:0], lo_q} : vec_q;
  assign pc_out   = vec_q;
  assign sp_out   = sp_q - PUSH_CNT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      psr_q <= '0;
      sp_q  <= '0;
      lo_q  <= '0;
      vec_q <= '0;
    end else begin
      if (load) begin
        pc_q  <= pc_in;
        psr_q <= psr_in;
        sp_q  <= sp_in;
      end
      if (state_q == ST_VEC_LO) lo_q  <= rdata;
      if (state_q == ST_VEC_HI) vec_q <= vec_next;
    end
  end

  AST_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_LO) |=> $stable(lo_q)); // R5
endmodule

// File: rtl/ies_bus.sv
module ies_bus
  import ies_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ies_state_e        state_d,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_psr,
  input  logic [DATA_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] vec_next,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw,
  output logic              we,
  output logic              done
);
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = '1;
  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = VEC_HI_ADDR - ADDR_W'(1);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              we_d;

  always_comb begin
    addr_d  = addr;
    wdata_d = wdata;
    we_d    = 1'b0;
    unique case (state_d)
      ST_PUSH_HI: begin
        we_d = 1'b1; addr_d = {STACK_PAGE, cur_sp};
        wdata_d = cur_pc[ADDR_W-1:DATA_W];
      end
      ST_PUSH_LO: begin
        we_d = 1'b1; addr_d = {STACK_PAGE, cur_sp - ONE};
        wdata_d = cur_pc[DATA_W-1:0];
      end
      ST_PUSH_PSR: begin
        we_d = 1'b1; addr_d = {STACK_PAGE, cur_sp - TWO};
        wdata_d = cur_psr;
      end
      ST_VEC_LO: addr_d = VEC_LO_ADDR;
      ST_VEC_HI: addr_d = VEC_HI_ADDR;
      ST_FETCH:  addr_d = vec_next;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      wdata <= '0;
      we    <= 1'b0;
      rw    <= 1'b1;
      done  <= 1'b0;
    end else begin
      addr  <= addr_d;
      wdata <= wdata_d;
      we    <= we_d;
      rw    <= !we_d;
      done  <= (state_d == ST_FETCH);
    end
  end

  AST_WE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R4
  AST_WE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !rw); // R4
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rw && !we)); // R8
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              slow_mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] psr_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw,
  output logic              we,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sp_out
);
  ies_state_e        state_q, state_d;
  logic              load;
  logic [ADDR_W-1:0] cur_pc, vec_next;
  logic [DATA_W-1:0] cur_psr, cur_sp;

  ies_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .slow_mode(slow_mode),
    .state_q(state_q), .state_d(state_d), .load(load), .busy(busy)
  );

  ies_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .load(load), .state_q(state_q), .rdata(rdata),
    .pc_in(pc_in), .psr_in(psr_in), .sp_in(sp_in),
    .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_sp(cur_sp),
    .vec_next(vec_next), .pc_out(pc_out), .sp_out(sp_out)
  );

  ies_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE)) u_bus (
    .clk(clk), .rst_n(rst_n), .state_d(state_d),
    .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_sp(cur_sp), .vec_next(vec_next),
    .addr(addr), .wdata(wdata), .rw(rw), .we(we), .done(done)
  );
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        slow_mode = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  psr_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  rdata;
  logic [15:0] addr, pc_out;
  logic [7:0]  wdata, sp_out;
  logic        rw, we, busy, done;
  logic [7:0]  vlo, vhi;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // Vector ROM at the top two addresses; other memory reads 0.
  always_comb begin
    if (addr == 16'hFFFE)      rdata = vlo;
    else if (addr == 16'hFFFF) rdata = vhi;
    else                       rdata = 8'h00;
  end

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slow_mode(slow_mode),
    .pc_in(pc_in), .psr_in(psr_in), .sp_in(sp_in), .rdata(rdata),
    .addr(addr), .wdata(wdata), .rw(rw), .we(we), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  sps [5];
    logic [15:0] pcs [3];
    logic [7:0]  pss [3];
    logic [15:0] vecs [3];
    sps  = '{8'hFF, 8'h00, 8'h01, 8'h02, 8'h80};
    pcs  = '{16'h1234, 16'hABCD, 16'h00FF};
    pss  = '{8'h24, 8'hB5, 8'h00};
    vecs = '{16'hC000, 16'h5A3C, 16'hFFFE};
    vlo = 8'h00; vhi = 8'h00;

    repeat (3) @(negedge clk);
    chk("R1", "we", we, 0);
    chk("R1", "rw", rw, 1);
    chk("R1", "done", done, 0);
    chk("R1", "busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 5; s++) begin
        for (int p = 0; p < 3; p++) begin
          logic [7:0]  sp, psr;
          logic [15:0] pc, vec;
          int          n;
          logic        prev_we;
          string       rq;
          sp = sps[s]; pc = pcs[p]; psr = pss[p]; vec = vecs[(p + s) % 3];
          n = m ? 8 : 6;
          rq = m ? "R7" : "R2";
          vlo = vec[7:0]; vhi = vec[15:8];
          pc_in = pc; psr_in = psr; sp_in = sp; slow_mode = m[0];
          start = 1'b1;
          prev_we = 1'b0;
          for (int k = 1; k <= n; k++) begin
            logic        e_we, e_addr_chk;
            logic [15:0] e_addr;
            logic [7:0]  e_wd;
            @(negedge clk);
            e_we = 0; e_addr_chk = 0; e_addr = '0; e_wd = '0;
            if (m == 0) begin
              case (k)
                1: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, sp}; e_wd = pc[15:8]; end
                2: begin e_addr_chk = 1; e_addr = 16'hFFFE; end
                3: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, 8'(sp - 1)}; e_wd = pc[7:0]; end
                4: begin e_addr_chk = 1; e_addr = 16'hFFFF; end
                5: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, 8'(sp - 2)}; e_wd = psr; end
                default: begin e_addr_chk = 1; e_addr = vec; end
              endcase
            end else begin
              case (k)
                1: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, sp}; e_wd = pc[15:8]; end
                3: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, 8'(sp - 1)}; e_wd = pc[7:0]; end
                5: begin e_we = 1; e_addr_chk = 1; e_addr = {8'h01, 8'(sp - 2)}; e_wd = psr; end
                6: begin e_addr_chk = 1; e_addr = 16'hFFFE; end
                7: begin e_addr_chk = 1; e_addr = 16'hFFFF; end
                8: begin e_addr_chk = 1; e_addr = vec; end
                default: ;
              endcase
            end
            chk(rq, $sformatf("we step %0d", k), we, e_we);
            if (e_we) begin
              chk("R4", $sformatf("rw on write step %0d", k), rw, 0);
              chk(k >= 3 ? "R9" : "R4", $sformatf("wdata step %0d", k), wdata, e_wd);
            end else begin
              chk("R8", $sformatf("rw on non-write step %0d", k), rw, 1);
            end
            if (e_addr_chk)
              chk((sp < 8'h02 && e_we) ? "R6" : rq, $sformatf("addr step %0d", k), addr, e_addr);
            chk("R4", $sformatf("no back-to-back we step %0d", k), prev_we && we, 0);
            chk("R3", $sformatf("done step %0d", k), done, k == n);
            prev_we = we;
            if (k == 1) start = 1'b0;
            if (k == 2) begin
              start = 1'b1; slow_mode = ~m[0];
              pc_in = ~pc; psr_in = ~psr; sp_in = sp + 8'h40;
            end
            if (k == 3) start = 1'b0;
            if (k == n) begin
              chk("R5", "pc_out at done", pc_out, vec);
              chk("R6", "sp_out at done", sp_out, 8'(sp - 3));
            end
          end
          @(negedge clk);
          chk("R3", "done after fetch", done, 0);
          chk("R8", "we idle", we, 0);
          chk("R8", "rw idle", rw, 1);
          chk("R9", "busy after sequence", busy, 0);
          chk("R5", "pc_out held", pc_out, vec);
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule